// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block watches the load and store traffic of a processor core against a bank of data watchpoints. Each watchpoint holds a word-aligned address and a control word. The control word selects the enable, the privilege filter, the access-type filter, the byte lanes to watch and a power-of-two address range mask. Every cycle the core can present one access. The access carries an address, a byte size, a store flag and a privileged flag. The unit compares that access with every watchpoint in parallel.

A hit produces a one-cycle debug event in the following cycle. Two debug-mode bits steer the event. With the halting bit set, the event becomes a halt request. With only the monitor bit set, it becomes an abort request, but only while the OS lock is clear. An abort also latches a fault address and a read/write indication for the handler.

Software reaches all state through a small register port. With the default of four watchpoints the register map is as follows:
- Addresses 0 to 3 hold the watched addresses.
- Addresses 4 to 7 hold the control words.
- Address 8 holds the debug-mode bits.
- Address 9 holds the lock.

Top module: `wpt_unit`

## Requirements
- R1: After reset every control word and the debug-mode register read 0. The lock register reads 1 (locked), and both request outputs are low.
- R2: A watched-address register reads back its written value with bits [1:0] forced to 0. A control word reads back only its fields:
  - enable at bit 0
  - privilege select at [2:1]
  - access-type select at [4:3]
  - lane select at [8:5]
  - mask size at [28:24]
  
  All other bits read 0.
- R3: With mask size 0, a hit needs two things. Address bits [31:2] must equal the watched address. At least one accessed byte must fall on a set lane bit, where lane bit k stands for byte offset k. The access covers the bytes from offset addr[1:0] upward: size 0 is 1 byte, size 1 is 2 bytes, size 2 or 3 is 4 bytes. Bytes past offset 3 are dropped.
- R4: The access-type select works as follows: 01 matches loads only, 10 matches stores only, 11 matches both, and 00 never matches.
- R5: The privilege select works as follows: 01 matches privileged accesses only, 10 matches user accesses only, 11 matches both, and 00 never matches.
- R6: A mask size of 1 or 2 never matches. A mask size m of 3 or more compares only address bits [31:m] and ignores the lane select.
- R7: A debug event is a single-cycle pulse in the cycle after an access presented with valid high. An access with valid low gives no event.
- R8: When several watchpoints hit together, hit_id_o reports the lowest-numbered one.
- R9: A hit while the halting bit (bit 14 of the debug-mode register) is set raises halt_req_o and never abort_req_o.
- R10: A hit while the monitor bit (bit 15) is set, the halting bit is clear and the lock is clear raises abort_req_o.
- R11: Writing 0xC5ACCE55 to the lock register sets the lock, and writing any other value clears it. While the lock is set, no abort is raised.
- R12: On an abort, the unit sets fault_wp_o. It loads fault_addr_o with the access address and fault_wnr_o with the store flag. All three then hold until the next abort.
- R13: A watchpoint whose enable bit is 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| acc_valid_i | input | 1 | Access presented this cycle |
| acc_addr_i | input | 32 | Access virtual address |
| acc_size_i | input | 2 | Access size code |
| acc_store_i | input | 1 | 1 for a store, 0 for a load |
| acc_priv_i | input | 1 | 1 for a privileged access |
| halt_req_o | output | 1 | Halt request pulse |
| abort_req_o | output | 1 | Abort request pulse |
| hit_id_o | output | 2 | Index of the reported watchpoint |
| fault_wp_o | output | 1 | Last abort came from a watchpoint |
| fault_wnr_o | output | 1 | Last abort was a store |
| fault_addr_o | output | 32 | Address of the last aborting access |

## Verification
The bench presents each access for exactly one clock edge. It then reads halt_req_o, abort_req_o, hit_id_o and the fault outputs at the next falling edge. That is the cycle after the access, one register stage away. The same outputs are read one cycle later to confirm that the pulse has gone and that the fault values are held. Register writes take effect at the edge that accepts them. Register reads are combinational and are sampled within the same low phase. The sweeps cover every privilege and access-type code, every lane pattern against every offset and size, and every mask size with addresses just inside and just outside the masked range.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] LOCK_KEY = 32'hC5AC_CE55;
  localparam int unsigned HALT_BIT = 14;
  localparam int unsigned MON_BIT  = 15;

  typedef struct packed {
    logic [4:0] msk;
    logic [3:0] bas;
    logic [1:0] lsc;
    logic [1:0] pac;
    logic       en;
  } wp_ctrl_t;

  function automatic wp_ctrl_t unpack_ctrl(input logic [DW-1:0] w);
    wp_ctrl_t c;
    c.en  = w[0];
    c.pac = w[2:1];
    c.lsc = w[4:3];
    c.bas = w[8:5];
    c.msk = w[28:24];
    return c;
  endfunction

  function automatic logic [DW-1:0] pack_ctrl(input wp_ctrl_t c);
    logic [DW-1:0] w;
    w        = '0;
    w[0]     = c.en;
    w[2:1]   = c.pac;
    w[4:3]   = c.lsc;
    w[8:5]   = c.bas;
    w[28:24] = c.msk;
    return w;
  endfunction
endpackage

// File: rtl/wpt_regs.sv
module wpt_regs import wpt_pkg::*; #(
  parameter int unsigned NUM_WP = 4,
  parameter int unsigned AW     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [DW-1:2]      wval_o [NUM_WP],
  output wp_ctrl_t           wctrl_o [NUM_WP],
  output logic               halt_en_o,
  output logic               mon_en_o,
  output logic               os_lock_o
);
  localparam int unsigned DBG_IDX  = 2 * NUM_WP;
  localparam int unsigned LOCK_IDX = 2 * NUM_WP + 1;

  logic [DW-1:2] wval_q  [NUM_WP];
  wp_ctrl_t      wctrl_q [NUM_WP];
  logic          halt_en_q, mon_en_q, lock_q;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wval_q[g]  <= '0;
        wctrl_q[g] <= '0;
      end else if (we_i) begin
        if (32'(addr_i) == g)          wval_q[g]  <= wdata_i[DW-1:2];
        if (32'(addr_i) == g + NUM_WP) wctrl_q[g] <= unpack_ctrl(wdata_i);
      end
    end
    assign wval_o[g]  = wval_q[g];
    assign wctrl_o[g] = wctrl_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_en_q <= 1'b0;
      mon_en_q  <= 1'b0;
      lock_q    <= 1'b1;
    end else if (we_i) begin
      if (32'(addr_i) == DBG_IDX) begin
        halt_en_q <= wdata_i[HALT_BIT];
        mon_en_q  <= wdata_i[MON_BIT];
      end
      if (32'(addr_i) == LOCK_IDX) lock_q <= (wdata_i == LOCK_KEY);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_WP; i++) begin
      if (32'(addr_i) == i)          rdata_o = {wval_q[i], 2'b00};
      if (32'(addr_i) == i + NUM_WP) rdata_o = pack_ctrl(wctrl_q[i]);
    end
    if (32'(addr_i) == DBG_IDX) begin
      rdata_o[HALT_BIT] = halt_en_q;
      rdata_o[MON_BIT]  = mon_en_q;
    end
    if (32'(addr_i) == LOCK_IDX) rdata_o[0] = lock_q;
  end

  assign halt_en_o = halt_en_q;
  assign mon_en_o  = mon_en_q;
  assign os_lock_o = lock_q;
endmodule

// File: rtl/wpt_match.sv
module wpt_match import wpt_pkg::*; (
  input  wp_ctrl_t         ctrl_i,
  input  logic [DW-1:2]    wval_i,
  input  logic             valid_i,
  input  logic [DW-1:0]    addr_i,
  input  logic [1:0]       size_i,
  input  logic             store_i,
  input  logic             priv_i,
  output logic             hit_o
);
  logic [3:0]    lane_base, lanes;
  logic [DW-1:0] care;
  logic          type_ok, priv_ok, addr_ok, msk_rsvd;

  always_comb begin
    unique case (size_i)
      2'd0:    lane_base = 4'b0001;
      2'd1:    lane_base = 4'b0011;
      default: lane_base = 4'b1111;
    endcase
    lanes = lane_base << addr_i[1:0];
  end

  always_comb begin
    for (int b = 0; b < DW; b++) care[b] = (b >= int'(ctrl_i.msk));
  end

  assign msk_rsvd = (ctrl_i.msk == 5'd1) || (ctrl_i.msk == 5'd2);
  assign type_ok  = store_i ? ctrl_i.lsc[1] : ctrl_i.lsc[0];
  assign priv_ok  = priv_i  ? ctrl_i.pac[0] : ctrl_i.pac[1];

  always_comb begin
    if (ctrl_i.msk == 5'd0)
      addr_ok = (addr_i[DW-1:2] == wval_i) && |(lanes & ctrl_i.bas);
    else
      addr_ok = ~|((addr_i ^ {wval_i, 2'b00}) & care);
  end

  assign hit_o = valid_i && ctrl_i.en && !msk_rsvd && type_ok && priv_ok && addr_ok;
endmodule

// File: rtl/wpt_route.sv
module wpt_route import wpt_pkg::*; #(
  parameter int unsigned NUM_WP = 4,
  parameter int unsigned IDW    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_WP-1:0]  hit_i,
  input  logic [DW-1:0]      addr_i,
  input  logic               store_i,
  input  logic               halt_en_i,
  input  logic               mon_en_i,
  input  logic               os_lock_i,
  output logic               halt_req_o,
  output logic               abort_req_o,
  output logic [IDW-1:0]     hit_id_o,
  output logic               fault_wp_o,
  output logic               fault_wnr_o,
  output logic [DW-1:0]      fault_addr_o
);
  logic           any_hit, take_abort;
  logic [IDW-1:0] first_id;

  always_comb begin
    first_id = '0;
    for (int i = NUM_WP - 1; i >= 0; i--) if (hit_i[i]) first_id = IDW'(i);
  end

  assign any_hit    = |hit_i;
  assign take_abort = any_hit && !halt_en_i && mon_en_i && !os_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_req_o   <= 1'b0;
      abort_req_o  <= 1'b0;
      hit_id_o     <= '0;
      fault_wp_o   <= 1'b0;
      fault_wnr_o  <= 1'b0;
      fault_addr_o <= '0;
    end else begin
      halt_req_o  <= any_hit && halt_en_i;
      abort_req_o <= take_abort;
      if (any_hit) hit_id_o <= first_id;
      if (take_abort) begin
        fault_wp_o   <= 1'b1;
        fault_wnr_o  <= store_i;
        fault_addr_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/wpt_unit.sv
module wpt_unit import wpt_pkg::*; #(
  parameter int unsigned NUM_WP = 4,
  localparam int unsigned AW    = $clog2(2 * NUM_WP + 2),
  localparam int unsigned IDW   = $clog2(NUM_WP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [31:0]     cfg_wdata_i,
  output logic [31:0]     cfg_rdata_o,
  input  logic            acc_valid_i,
  input  logic [31:0]     acc_addr_i,
  input  logic [1:0]      acc_size_i,
  input  logic            acc_store_i,
  input  logic            acc_priv_i,
  output logic            halt_req_o,
  output logic            abort_req_o,
  output logic [IDW-1:0]  hit_id_o,
  output logic            fault_wp_o,
  output logic            fault_wnr_o,
  output logic [31:0]     fault_addr_o
);
  logic [DW-1:2]     wval  [NUM_WP];
  wp_ctrl_t          wctrl [NUM_WP];
  logic              halt_en, mon_en, os_lock;
  logic [NUM_WP-1:0] hit_vec;

  wpt_regs #(.NUM_WP(NUM_WP), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .wval_o(wval), .wctrl_o(wctrl),
    .halt_en_o(halt_en), .mon_en_o(mon_en), .os_lock_o(os_lock)
  );

  for (genvar g = 0; g < NUM_WP; g++) begin : g_cmp
    wpt_match u_match (
      .ctrl_i(wctrl[g]), .wval_i(wval[g]), .valid_i(acc_valid_i),
      .addr_i(acc_addr_i), .size_i(acc_size_i), .store_i(acc_store_i),
      .priv_i(acc_priv_i), .hit_o(hit_vec[g])
    );
  end

  wpt_route #(.NUM_WP(NUM_WP), .IDW(IDW)) u_route (
    .clk_i, .rst_ni,
    .hit_i(hit_vec), .addr_i(acc_addr_i), .store_i(acc_store_i),
    .halt_en_i(halt_en), .mon_en_i(mon_en), .os_lock_i(os_lock),
    .halt_req_o, .abort_req_o, .hit_id_o,
    .fault_wp_o, .fault_wnr_o, .fault_addr_o
  );
endmodule

// File: rtl/wpt_unit_chk.sv
module wpt_unit_chk #(
  parameter int unsigned NUM_WP = 4,
  parameter int unsigned AW     = 4,
  parameter int unsigned IDW    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [AW-1:0]     cfg_addr_i,
  input logic [31:0]       cfg_wdata_i,
  input logic              acc_valid_i,
  input logic [31:0]       acc_addr_i,
  input logic              acc_store_i,
  input logic              halt_req_o,
  input logic              abort_req_o,
  input logic [IDW-1:0]    hit_id_o,
  input logic              fault_wp_o,
  input logic              fault_wnr_o,
  input logic [31:0]       fault_addr_o,
  input logic              halt_en,
  input logic              mon_en,
  input logic              os_lock,
  input logic [NUM_WP-1:0] hit_vec
);
  localparam logic [AW-1:0] LOCK_A = AW'(2 * NUM_WP + 1);

  logic [NUM_WP-1:0] prev_hit;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_hit <= '0;
    else         prev_hit <= hit_vec;

  // R7
  evt_needs_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_req_o || abort_req_o) |-> $past(acc_valid_i));
  // R9
  halt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o |-> !halt_req_o);
  // R9
  halt_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> $past(halt_en));
  // R11
  lock_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o |-> $past(mon_en && !os_lock));
  // R11
  key_sets_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == LOCK_A && cfg_wdata_i == 32'hC5AC_CE55) |=> os_lock);
  // R12
  fault_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req_o |-> (fault_wp_o && fault_addr_o == $past(acc_addr_i)
                     && fault_wnr_o == $past(acc_store_i)));
  // R12
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_req_o |-> ($stable(fault_addr_o) && $stable(fault_wnr_o)));
  // R8
  lowest_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> (prev_hit[hit_id_o]
                    && (prev_hit & ((NUM_WP'(1) << hit_id_o) - NUM_WP'(1))) == '0));
endmodule

bind wpt_unit wpt_unit_chk #(.NUM_WP(NUM_WP), .AW(AW), .IDW(IDW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
  .acc_store_i(acc_store_i), .halt_req_o(halt_req_o), .abort_req_o(abort_req_o),
  .hit_id_o(hit_id_o), .fault_wp_o(fault_wp_o), .fault_wnr_o(fault_wnr_o),
  .fault_addr_o(fault_addr_o), .halt_en(halt_en), .mon_en(mon_en),
  .os_lock(os_lock), .hit_vec(hit_vec)
);

// File: tb/tb_wpt_unit.sv
`timescale 1ns/1ps
module tb_wpt_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic        acc_store_i = 1'b0;
  logic        acc_priv_i = 1'b0;
  logic        halt_req_o, abort_req_o, fault_wp_o, fault_wnr_o;
  logic [1:0]  hit_id_o;
  logic [31:0] fault_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  wpt_unit dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  // presents one access; returns at the falling edge after the capturing edge
  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic st,
                     input logic pv, input logic v);
    @(negedge clk_i);
    acc_valid_i = v; acc_addr_i = a; acc_size_i = sz; acc_store_i = st; acc_priv_i = pv;
    @(negedge clk_i);
    acc_valid_i = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(input logic en, input logic [1:0] pac,
      input logic [1:0] lsc, input logic [3:0] bas, input logic [4:0] msk);
    return {3'b0, msk, 15'b0, bas, lsc, pac, en};
  endfunction

  // reference from R3..R6, R13
  function automatic logic ref_hit(input logic [31:0] c, input logic [31:0] v,
      input logic [31:0] a, input logic [1:0] sz, input logic st, input logic pv);
    int m, nb, off;
    logic [3:0] ln;
    if (!c[0]) return 1'b0;
    if (st ? !c[4] : !c[3]) return 1'b0;
    if (pv ? !c[1] : !c[2]) return 1'b0;
    m = int'(c[28:24]);
    if (m == 1 || m == 2) return 1'b0;
    if (m >= 3) return ((a >> m) == ((v & 32'hFFFF_FFFC) >> m));
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    off = int'(a[1:0]);
    ln = '0;
    for (int k = 0; k < 4; k++) if (k >= off && k < off + nb) ln[k] = 1'b1;
    return (a[31:2] == v[31:2]) && |(ln & c[8:5]);
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, c, base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int i = 4; i < 8; i++) begin rd(4'(i), d); chk(d, 0, "R1 ctrl"); end
    rd(4'd8, d); chk(d, 0, "R1 dbg");
    rd(4'd9, d); chk(d, 1, "R1 lock");
    chk({30'b0, halt_req_o, abort_req_o}, 0, "R1 req");

    // R2 readback
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, d); chk(d, 32'hFFFF_FFFC, "R2 value");
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, d); chk(d, 32'h1F00_01FF, "R2 ctrl");
    wr(4'd4, 0);

    wr(4'd8, 32'h0000_4000);
    wr(4'd0, 32'h0000_1000);

    // R13 disabled
    wr(4'd4, mk_ctrl(0, 3, 3, 4'hF, 0));
    acc(32'h1000, 2, 0, 1, 1); chk(halt_req_o, 0, "R13 disabled");

    // R4 R5 filter sweep
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 4; l++) begin
        c = mk_ctrl(1, 2'(p), 2'(l), 4'hF, 0);
        wr(4'd4, c);
        for (int s = 0; s < 2; s++)
          for (int v = 0; v < 2; v++) begin
            acc(32'h1000, 2, 1'(s), 1'(v), 1);
            chk(halt_req_o, ref_hit(c, 32'h1000, 32'h1000, 2, 1'(s), 1'(v)), "R4 R5 filter");
          end
      end

    // R3 lane sweep
    for (int b = 0; b < 16; b++) begin
      c = mk_ctrl(1, 3, 3, 4'(b), 0);
      wr(4'd4, c);
      for (int o = 0; o < 4; o++)
        for (int z = 0; z < 4; z++) begin
          acc(32'h1000 | 32'(o), 2'(z), 0, 1, 1);
          chk(halt_req_o, ref_hit(c, 32'h1000, 32'h1000 | 32'(o), 2'(z), 0, 1), "R3 lanes");
        end
      acc(32'h1004, 2, 0, 1, 1); chk(halt_req_o, 0, "R3 other word");
    end

    // R6 mask sweep
    base = 32'hA5A5_5A5C;
    wr(4'd0, base);
    for (int m = 0; m < 32; m++) begin
      c = mk_ctrl(1, 3, 3, 4'b0001, 5'(m));
      wr(4'd4, c);
      acc(base, 0, 0, 1, 1);
      chk(halt_req_o, ref_hit(c, base, base, 0, 0, 1), "R6 base");
      acc(base | 3, 0, 0, 1, 1);
      chk(halt_req_o, ref_hit(c, base, base | 3, 0, 0, 1), "R6 lanes ignored");
      acc(base ^ (32'h1 << m), 0, 0, 1, 1);
      chk(halt_req_o, ref_hit(c, base, base ^ (32'h1 << m), 0, 0, 1), "R6 outside");
      if (m > 0) begin
        acc(base ^ (32'h1 << (m - 1)), 0, 0, 1, 1);
        chk(halt_req_o, ref_hit(c, base, base ^ (32'h1 << (m - 1)), 0, 0, 1), "R6 inside");
      end
    end
    wr(4'd4, 0);

    // R7 pulse and valid
    wr(4'd0, 32'h1000); wr(4'd4, mk_ctrl(1, 3, 3, 4'hF, 0));
    acc(32'h1000, 2, 0, 1, 1); chk(halt_req_o, 1, "R7 pulse");
    @(negedge clk_i); chk(halt_req_o, 0, "R7 single cycle");
    acc(32'h1000, 2, 0, 1, 0); chk(halt_req_o, 0, "R7 no valid");
    wr(4'd4, 0);

    // R8 priority
    for (int i = 1; i < 4; i++) begin
      wr(4'(i), 32'h2000); wr(4'(i + 4), mk_ctrl(1, 3, 3, 4'hF, 0));
    end
    acc(32'h2000, 2, 0, 1, 1);
    chk(halt_req_o, 1, "R8 hit"); chk(hit_id_o, 1, "R8 lowest");
    wr(4'd5, 0);
    acc(32'h2000, 2, 0, 1, 1); chk(hit_id_o, 2, "R8 next lowest");

    // R10 R11 monitor route behind lock
    wr(4'd8, 32'h0000_8000);
    acc(32'h2000, 2, 1, 1, 1);
    chk(abort_req_o, 0, "R11 locked"); chk(fault_wp_o, 0, "R11 no fault");
    wr(4'd9, 32'h0);
    rd(4'd9, d); chk(d, 0, "R11 unlock");
    acc(32'h2002, 0, 1, 0, 1);
    chk(abort_req_o, 1, "R10 abort"); chk(halt_req_o, 0, "R10 no halt");
    chk(fault_addr_o, 32'h2002, "R12 addr"); chk(fault_wnr_o, 1, "R12 store");
    chk(fault_wp_o, 1, "R12 status");
    @(negedge clk_i);
    chk(abort_req_o, 0, "R7 abort pulse"); chk(fault_addr_o, 32'h2002, "R12 hold");
    acc(32'h2001, 0, 0, 1, 1);
    chk(abort_req_o, 1, "R10 load abort"); chk(fault_wnr_o, 0, "R12 load");
    chk(fault_addr_o, 32'h2001, "R12 addr load");
    wr(4'd9, 32'hC5AC_CE55);
    rd(4'd9, d); chk(d, 1, "R11 key locks");
    acc(32'h2000, 2, 1, 1, 1);
    chk(abort_req_o, 0, "R11 relocked"); chk(fault_addr_o, 32'h2001, "R12 held");

    // R9 halt over monitor
    wr(4'd8, 32'h0000_C000); wr(4'd9, 32'h1);
    acc(32'h2000, 2, 1, 1, 1);
    chk(halt_req_o, 1, "R9 halt"); chk(abort_req_o, 0, "R9 no abort");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule